// File: doc/BRIEF.md
# Debug System Bus Access Master

This block lets a debugger reach system memory without involving a processor. The debugger loads a 64-bit address and, for writes, a 64-bit data value into four 32-bit registers. It picks an access size in a control register and then pulses a read or a write strobe. The block issues one request on a simple request/response memory port and waits for the response. For a read, it returns the loaded value in the data registers.

The widest access the block supports is fixed at build time by `MAX_BITS`. That value decides which capability flags the control register shows. It also decides which size codes the block accepts and which it rejects with a size error. Errors are held in a sticky field that the debugger clears by writing ones. An optional auto-increment moves the address forward by the access size after each successful access, so the debugger can step through memory.

Register select codes are 0 for control, 1 for address low, 2 for address high, 3 for data low and 4 for data high. The control word holds these fields:

- bits [2:0]: size code
- bit 3: auto-increment enable
- bits [6:4]: error code
- bit 7: busy (read only)
- bit 8: busy error (write 1 to clear)
- bits [12:9]: capability flags for 8, 16, 32 and 64 bits, with the lowest bit for 8 bits
- bits [19:13]: address size
- bits [31:29]: version

Top module: `sba_master`

## Requirements
- R1: After reset, the address and data registers read 0. The control word shows error 0, busy 0 and busy error 0. Its capability flags, address size and version are the ones set by `MAX_BITS`.
- R2: The capability flag for width w (8, 16, 32 or 64) is 1 only when `MAX_BITS` >= w. Version reads 1 and address size reads 64 when `MAX_BITS` > 0. Both read 0 when `MAX_BITS` is 0.
- R3: Size code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. An accepted access raises `bus_req_o` for exactly one cycle. It drives `bus_addr_o` = {address high, address low} and `bus_size_o` = the size code.
- R4: A read of 8, 16 or 32 bits places the returned low bits, zero-extended, in data low and leaves data high unchanged. A 64-bit read places bits [31:0] in data low and bits [63:32] in data high.
- R5: A write drives `bus_wdata_o` = {data high, data low} with `bus_we_o` = 1.
- R6: A read or write is rejected when its size code is above 3 or wider than `MAX_BITS`. A rejected access makes no bus request and sets the error field to 3.
- R7: A response with `bus_fault_i` set, on a read or a write, sets the error field to 2. It leaves the data registers and the address unchanged.
- R8: With auto-increment enabled, a successful access adds the access size in bytes to the 64-bit address. A carry out of address low goes into address high. With auto-increment disabled, the address is kept.
- R9: The error field is sticky. It clears only where the debugger writes 1s to bits [6:4] of the control word.
- R10: Busy is high from the cycle after a request is issued until the response is taken. A read or write strobe seen while busy is ignored and sets the busy error flag.
- R11: When `MAX_BITS` is 0, auto-increment never changes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected register value |
| rd_go_i | input | 1 | Start a read |
| wr_go_i | input | 1 | Start a write (wins over read) |
| busy_o | output | 1 | Access outstanding |
| bus_req_o | output | 1 | One-cycle request pulse |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | 64 | Request address |
| bus_size_o | output | 2 | Request size code |
| bus_wdata_o | output | 64 | Write data |
| bus_rsp_i | input | 1 | Response valid |
| bus_rdata_i | input | 64 | Read data |
| bus_fault_i | input | 1 | Response carries a fault |

## Verification
The assertions assume that the memory port answers each request exactly once, after the request and never before it. They also assume that a response arriving while the block is idle is not meaningful. The bench memory model meets this by answering every request with a single response two cycles later. It faults any address whose top nibble is F. The stimulus pulses one strobe at a time and checks results only after busy has dropped. A busy-error case is the one exception: there a second strobe is given on purpose while the access is still outstanding.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2 * WORD_W;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } sba_sel_e;

  localparam logic [2:0] ERR_FAULT = 3'd2;
  localparam logic [2:0] ERR_SIZE  = 3'd3;

  // control word field positions
  localparam int unsigned CTL_SIZE_LSB = 0;
  localparam int unsigned CTL_AINC_BIT = 3;
  localparam int unsigned CTL_ERR_LSB  = 4;
  localparam int unsigned CTL_BUSY_BIT = 7;
  localparam int unsigned CTL_BERR_BIT = 8;
  localparam int unsigned CTL_CAP_LSB  = 9;
  localparam int unsigned CTL_ASZ_LSB  = 13;
  localparam int unsigned CTL_VER_LSB  = 29;
endpackage

// File: rtl/sba_cap.sv
module sba_cap #(
  parameter int unsigned MAX_BITS = 64
) (
  input  logic [2:0] size_code_i,
  output logic [3:0] cap_o,
  output logic       size_ok_o,
  output logic [2:0] version_o,
  output logic [6:0] asize_o
);
  localparam bit HAS_BUS = (MAX_BITS > 0);

  for (genvar i = 0; i < 4; i++) begin : g_cap
    assign cap_o[i] = (MAX_BITS >= (32'd8 << i)) ? 1'b1 : 1'b0;
  end

  assign size_ok_o = !size_code_i[2] && cap_o[size_code_i[1:0]];
  assign version_o = HAS_BUS ? 3'd1 : 3'd0;
  assign asize_o   = HAS_BUS ? 7'd64 : 7'd0;
endmodule

// File: rtl/sba_addr.sv
module sba_addr #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              inc_i,
  input  logic [3:0]        inc_bytes_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] addr_q, addr_sum;

  // full-width add carries low word into high word
  assign addr_sum = addr_q + {{(AW-4){1'b0}}, inc_bytes_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_sum;
    end else begin
      if (lo_we_i) addr_q[WORD_W-1:0]  <= wdata_i;
      if (hi_we_i) addr_q[AW-1:WORD_W] <= wdata_i;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sba_data.sv
module sba_data #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned DW = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic [1:0]        load_size_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [DW-1:0]     data_o
);
  logic [WORD_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      unique case (load_size_i)
        2'd0: lo_q <= {{(WORD_W-8){1'b0}}, rdata_i[7:0]};
        2'd1: lo_q <= {{(WORD_W-16){1'b0}}, rdata_i[15:0]};
        2'd2: lo_q <= rdata_i[WORD_W-1:0];
        default: begin
          lo_q <= rdata_i[WORD_W-1:0];
          hi_q <= rdata_i[DW-1:WORD_W];
        end
      endcase
    end else begin
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i;
    end
  end

  assign data_o = {hi_q, lo_q};
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int unsigned MAX_BITS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rd_go_i,
  input  logic        wr_go_i,
  output logic        busy_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [63:0] bus_addr_o,
  output logic [1:0]  bus_size_o,
  output logic [63:0] bus_wdata_o,
  input  logic        bus_rsp_i,
  input  logic [63:0] bus_rdata_i,
  input  logic        bus_fault_i
);
  localparam bit HAS_BUS = (MAX_BITS > 0);

  sba_sel_e sel;
  assign sel = sba_sel_e'(reg_sel_i);

  logic [2:0] size_q;
  logic       ainc_q;
  logic [2:0] err_q, err_d;
  logic       busy_q, berr_q, berr_d;
  logic       req_q, pend_we_q;
  logic [1:0] pend_size_q;

  logic [3:0] cap;
  logic       size_ok;
  logic [2:0] version;
  logic [6:0] asize;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] data;

  logic go, issue, bad_size, clash, done, ctrl_we;
  assign go       = rd_go_i || wr_go_i;
  assign issue    = go && !busy_q && size_ok;
  assign bad_size = go && !busy_q && !size_ok;
  assign clash    = go && busy_q;
  assign done     = bus_rsp_i && busy_q;
  assign ctrl_we  = reg_we_i && (sel == SEL_CTRL);

  sba_cap #(.MAX_BITS(MAX_BITS)) u_cap (
    .size_code_i (size_q),
    .cap_o       (cap),
    .size_ok_o   (size_ok),
    .version_o   (version),
    .asize_o     (asize)
  );

  sba_addr #(.WORD_W(WORD_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_we_i     (reg_we_i && sel == SEL_ADDR_LO),
    .hi_we_i     (reg_we_i && sel == SEL_ADDR_HI),
    .wdata_i     (reg_wdata_i),
    .inc_i       (HAS_BUS && done && !bus_fault_i && ainc_q),
    .inc_bytes_i (4'd1 << pend_size_q),
    .addr_o      (addr)
  );

  sba_data #(.WORD_W(WORD_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_we_i     (reg_we_i && sel == SEL_DATA_LO),
    .hi_we_i     (reg_we_i && sel == SEL_DATA_HI),
    .wdata_i     (reg_wdata_i),
    .load_i      (done && !pend_we_q && !bus_fault_i),
    .load_size_i (pend_size_q),
    .rdata_i     (bus_rdata_i),
    .data_o      (data)
  );

  // W1C first, then new events override
  always_comb begin
    err_d  = err_q;
    berr_d = berr_q;
    if (ctrl_we) begin
      err_d  = err_q & ~reg_wdata_i[CTL_ERR_LSB +: 3];
      berr_d = berr_q & ~reg_wdata_i[CTL_BERR_BIT];
    end
    if (bad_size)             err_d  = ERR_SIZE;
    if (done && bus_fault_i)  err_d  = ERR_FAULT;
    if (clash)                berr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q      <= '0;
      ainc_q      <= 1'b0;
      err_q       <= '0;
      berr_q      <= 1'b0;
      busy_q      <= 1'b0;
      req_q       <= 1'b0;
      pend_we_q   <= 1'b0;
      pend_size_q <= '0;
    end else begin
      err_q  <= err_d;
      berr_q <= berr_d;
      req_q  <= issue;
      if (ctrl_we) begin
        size_q <= reg_wdata_i[CTL_SIZE_LSB +: 3];
        ainc_q <= reg_wdata_i[CTL_AINC_BIT];
      end
      if (issue) begin
        busy_q      <= 1'b1;
        pend_we_q   <= wr_go_i;
        pend_size_q <= size_q[1:0];
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_SIZE_LSB +: 3] = size_q;
    ctrl_word[CTL_AINC_BIT]      = ainc_q;
    ctrl_word[CTL_ERR_LSB +: 3]  = err_q;
    ctrl_word[CTL_BUSY_BIT]      = busy_q;
    ctrl_word[CTL_BERR_BIT]      = berr_q;
    ctrl_word[CTL_CAP_LSB +: 4]  = cap;
    ctrl_word[CTL_ASZ_LSB +: 7]  = asize;
    ctrl_word[CTL_VER_LSB +: 3]  = version;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:    reg_rdata_o = ctrl_word;
      SEL_ADDR_LO: reg_rdata_o = addr[WORD_W-1:0];
      SEL_ADDR_HI: reg_rdata_o = addr[ADDR_W-1:WORD_W];
      SEL_DATA_LO: reg_rdata_o = data[WORD_W-1:0];
      SEL_DATA_HI: reg_rdata_o = data[ADDR_W-1:WORD_W];
      default:     reg_rdata_o = '0;
    endcase
  end

  assign busy_o      = busy_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = pend_we_q;
  assign bus_size_o  = pend_size_q;
  assign bus_addr_o  = addr;
  assign bus_wdata_o = data;
endmodule

// File: rtl/sba_master_chk.sv
module sba_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       busy_i,
  input logic       rsp_i,
  input logic       fault_i,
  input logic       go_i,
  input logic       size_ok_i,
  input logic [2:0] err_i,
  input logic       ctrl_we_i
);
  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rsp_i |=> busy_i);

  // R10
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rsp_i |=> !busy_i);

  // R10
  no_req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !req_i);

  // R6
  size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_i && !size_ok_i |=> !req_i && err_i == 3'd3);

  // R7
  fault_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rsp_i && fault_i |=> err_i == 3'd2);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i != 3'd0 && !ctrl_we_i |=> err_i != 3'd0);
endmodule

bind sba_master sba_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (bus_req_o),
  .busy_i    (busy_q),
  .rsp_i     (bus_rsp_i),
  .fault_i   (bus_fault_i),
  .go_i      (go),
  .size_ok_i (size_ok),
  .err_i     (err_q),
  .ctrl_we_i (ctrl_we)
);

// File: tb/test_sba_master.sv
`timescale 1ns/1ps
module test_sba_master;
  // unit 0: MAX_BITS 64, unit 1: 32, unit 2: 0
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic        we[3], rd_go[3], wr_go[3];
  logic [2:0]  sel[3];
  logic [31:0] wdata[3], rdata[3];
  logic        busy[3], req[3], bwe[3], rsp[3], fault[3];
  logic [63:0] baddr[3], bwdata[3], brdata[3];
  logic [1:0]  bsize[3];

  for (genvar g = 0; g < 3; g++) begin : g_dut
    sba_master #(.MAX_BITS(g == 0 ? 64 : (g == 1 ? 32 : 0))) i_sba_master (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .reg_we_i(we[g]), .reg_sel_i(sel[g]), .reg_wdata_i(wdata[g]),
      .reg_rdata_o(rdata[g]), .rd_go_i(rd_go[g]), .wr_go_i(wr_go[g]),
      .busy_o(busy[g]), .bus_req_o(req[g]), .bus_we_o(bwe[g]),
      .bus_addr_o(baddr[g]), .bus_size_o(bsize[g]), .bus_wdata_o(bwdata[g]),
      .bus_rsp_i(rsp[g]), .bus_rdata_i(brdata[g]), .bus_fault_i(fault[g])
    );
  end

  // memory model: answers two cycles after each request
  logic        v1[3];
  logic [63:0] a1[3];
  logic [63:0] last_addr[3], last_wdata[3];
  logic        last_we[3];
  logic [1:0]  last_size[3];
  int          req_cnt[3];

  function automatic logic [63:0] pat(logic [63:0] a);
    return {a[31:0] ^ 32'h5a5a_5a5a, a[31:0] + 32'h1234_5678};
  endfunction

  always @(posedge clk_i) begin
    for (int u = 0; u < 3; u++) begin
      if (!rst_ni) begin
        v1[u] <= 1'b0; rsp[u] <= 1'b0; fault[u] <= 1'b0; req_cnt[u] <= 0;
        a1[u] <= '0; brdata[u] <= '0;
      end else begin
        v1[u]     <= req[u];
        a1[u]     <= baddr[u];
        rsp[u]    <= v1[u];
        brdata[u] <= pat(a1[u]);
        fault[u]  <= v1[u] && (a1[u][63:60] == 4'hF);
        if (req[u]) begin
          req_cnt[u]    <= req_cnt[u] + 1;
          last_addr[u]  <= baddr[u];
          last_wdata[u] <= bwdata[u];
          last_we[u]    <= bwe[u];
          last_size[u]  <= bsize[u];
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(int u, logic [2:0] s, logic [31:0] d);
    @(negedge clk_i);
    we[u] = 1'b1; sel[u] = s; wdata[u] = d;
    @(negedge clk_i);
    we[u] = 1'b0;
  endtask

  task automatic reg_rd(int u, logic [2:0] s, output logic [31:0] d);
    @(negedge clk_i);
    sel[u] = s;
    #1 d = rdata[u];
  endtask

  function automatic logic [31:0] ctl(int sz, bit ai, bit clr);
    return 32'(sz) | (32'(ai) << 3) | (clr ? 32'h170 : 32'h0);
  endfunction

  task automatic access(int u, bit w);
    @(negedge clk_i);
    if (w) wr_go[u] = 1'b1; else rd_go[u] = 1'b1;
    @(negedge clk_i);
    rd_go[u] = 1'b0; wr_go[u] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!busy[u]) break;
      @(negedge clk_i);
    end
  endtask

  task automatic err_of(int u, output logic [2:0] e);
    logic [31:0] c;
    reg_rd(u, 3'd0, c);
    e = c[6:4];
  endtask

  task automatic test_reset();
    logic [31:0] d;
    reg_rd(0, 3'd0, d); chk("R1 R2 ctrl u64", d, 32'h2008_1E00);
    reg_rd(1, 3'd0, d); chk("R1 R2 ctrl u32", d, 32'h2008_0E00);
    reg_rd(2, 3'd0, d); chk("R1 R2 ctrl u0", d, 32'h0);
    for (int s = 1; s <= 4; s++) begin
      reg_rd(0, 3'(s), d); chk("R1 addr/data reset", d, 32'h0);
    end
  endtask

  task automatic test_read_sizes();
    logic [31:0] d;
    logic [63:0] p;
    logic [63:0] a = 64'h0000_0002_1000_0010;
    reg_wr(0, 3'd1, a[31:0]);
    reg_wr(0, 3'd2, a[63:32]);
    p = pat(a);
    for (int c = 0; c < 4; c++) begin
      reg_wr(0, 3'd4, 32'hDEAD_BEEF);
      reg_wr(0, 3'd0, ctl(c, 0, 0));
      access(0, 0);
      chk("R3 req addr", last_addr[0], a);
      chk("R3 req size", 64'(last_size[0]), 64'(c));
      reg_rd(0, 3'd3, d);
      case (c)
        0: chk("R4 read8 lo", d, {24'h0, p[7:0]});
        1: chk("R4 read16 lo", d, {16'h0, p[15:0]});
        default: chk("R4 read32/64 lo", d, p[31:0]);
      endcase
      reg_rd(0, 3'd4, d);
      chk("R4 read hi", d, (c == 3) ? p[63:32] : 32'hDEAD_BEEF);
    end
    // 32-bit cap unit still does 32-bit reads
    reg_wr(1, 3'd1, 32'h0000_0040);
    reg_wr(1, 3'd0, ctl(2, 0, 0));
    access(1, 0);
    reg_rd(1, 3'd3, d);
    chk("R4 u32 read32", d, pat(64'h40) & 64'hFFFF_FFFF);
  endtask

  task automatic test_write();
    reg_wr(0, 3'd3, 32'h1122_3344);
    reg_wr(0, 3'd4, 32'h5566_7788);
    reg_wr(0, 3'd0, ctl(3, 0, 0));
    access(0, 1);
    chk("R5 wdata", last_wdata[0], 64'h5566_7788_1122_3344);
    chk("R5 we", 64'(last_we[0]), 64'd1);
  endtask

  task automatic test_size_err();
    logic [2:0] e;
    int n0;
    n0 = req_cnt[0];
    reg_wr(0, 3'd0, ctl(5, 0, 1));
    access(0, 0);
    err_of(0, e); chk("R6 code 5 err", 64'(e), 64'd3);
    chk("R6 code 5 no req", 64'(req_cnt[0]), 64'(n0));
    reg_wr(1, 3'd0, ctl(3, 0, 1));
    access(1, 1);
    err_of(1, e); chk("R6 64 on 32-cap err", 64'(e), 64'd3);
    reg_wr(2, 3'd0, ctl(0, 0, 1));
    n0 = req_cnt[2];
    access(2, 0);
    err_of(2, e); chk("R6 8 on 0-cap err", 64'(e), 64'd3);
    chk("R6 0-cap no req", 64'(req_cnt[2]), 64'(n0));
  endtask

  task automatic test_sticky();
    logic [2:0] e;
    reg_wr(0, 3'd0, ctl(7, 0, 1));
    access(0, 0);
    reg_wr(0, 3'd0, ctl(2, 0, 0));
    err_of(0, e); chk("R9 kept on ctrl write w/o 1s", 64'(e), 64'd3);
    reg_wr(0, 3'd2, 32'h0);
    access(0, 0);
    err_of(0, e); chk("R9 kept after good access", 64'(e), 64'd3);
    reg_wr(0, 3'd0, ctl(2, 0, 1));
    err_of(0, e); chk("R9 cleared by 1s", 64'(e), 64'd0);
  endtask

  task automatic test_fault();
    logic [2:0] e;
    logic [31:0] d;
    reg_wr(0, 3'd3, 32'hCAFE_0001);
    reg_wr(0, 3'd1, 32'h0000_0010);
    reg_wr(0, 3'd2, 32'hF000_0000);
    reg_wr(0, 3'd0, ctl(2, 1, 1));
    access(0, 0);
    err_of(0, e); chk("R7 read fault err", 64'(e), 64'd2);
    reg_rd(0, 3'd3, d); chk("R7 data kept", d, 32'hCAFE_0001);
    reg_rd(0, 3'd1, d); chk("R7 addr kept", d, 32'h0000_0010);
    reg_wr(0, 3'd0, ctl(2, 0, 1));
    access(0, 1);
    err_of(0, e); chk("R7 write fault err", 64'(e), 64'd2);
    reg_wr(0, 3'd0, ctl(2, 0, 1));
  endtask

  task automatic test_autoinc();
    logic [31:0] d;
    logic [2:0] e;
    reg_wr(0, 3'd1, 32'hFFFF_FFFC);
    reg_wr(0, 3'd2, 32'h0000_0007);
    reg_wr(0, 3'd0, ctl(2, 1, 1));
    access(0, 0);
    reg_rd(0, 3'd1, d); chk("R8 carry lo", d, 32'h0);
    reg_rd(0, 3'd2, d); chk("R8 carry hi", d, 32'h8);
    reg_wr(0, 3'd0, ctl(0, 1, 0));
    access(0, 0);
    reg_rd(0, 3'd1, d); chk("R8 +1", d, 32'h1);
    reg_wr(0, 3'd0, ctl(3, 1, 0));
    access(0, 1);
    reg_rd(0, 3'd1, d); chk("R8 +8", d, 32'h9);
    reg_wr(0, 3'd0, ctl(2, 0, 0));
    access(0, 0);
    reg_rd(0, 3'd1, d); chk("R8 off keeps", d, 32'h9);
    // R11
    reg_wr(2, 3'd1, 32'h0000_0100);
    reg_wr(2, 3'd0, ctl(0, 1, 1));
    access(2, 0);
    reg_rd(2, 3'd1, d); chk("R11 0-cap addr kept", d, 32'h100);
    err_of(2, e); chk("R11 0-cap err", 64'(e), 64'd3);
  endtask

  task automatic test_busy();
    logic [31:0] d;
    int n0;
    reg_wr(0, 3'd2, 32'h0);
    reg_wr(0, 3'd0, ctl(2, 0, 1));
    n0 = req_cnt[0];
    @(negedge clk_i); rd_go[0] = 1'b1;
    @(negedge clk_i); rd_go[0] = 1'b0;
    chk("R10 busy after issue", 64'(busy[0]), 64'd1);
    wr_go[0] = 1'b1;
    @(negedge clk_i); wr_go[0] = 1'b0;
    chk("R10 still busy", 64'(busy[0]), 64'd1);
    for (int i = 0; i < 20; i++) begin
      if (!busy[0]) break;
      @(negedge clk_i);
    end
    chk("R10 busy drops", 64'(busy[0]), 64'd0);
    chk("R10 one request", 64'(req_cnt[0]), 64'(n0 + 1));
    chk("R10 was read", 64'(last_we[0]), 64'd0);
    reg_rd(0, 3'd0, d); chk("R10 busy error set", 64'(d[8]), 64'd1);
    reg_wr(0, 3'd0, 32'h102);
    reg_rd(0, 3'd0, d); chk("R10 busy error cleared", 64'(d[8]), 64'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    for (int u = 0; u < 3; u++) begin
      we[u] = 1'b0; rd_go[u] = 1'b0; wr_go[u] = 1'b0;
      sel[u] = 3'd0; wdata[u] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_read_sizes();
    test_write();
    test_size_err();
    test_sticky();
    test_fault();
    test_autoinc();
    test_busy();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule